// File: doc/BRIEF.md
# Line-Sync Reference Supervisor

This block decides whether a video clock generator tracks an incoming line-sync reference or runs on its local oscillator, and which of two reference ports it tracks. The operating mode and the port each come from a pin or from a configuration bit. A separate override bit forces the port choice onto the configuration bit and frees the select pin for other uses.

The selected line-sync input is checked for its active edge, whose direction is set per port. A missing pulse is counted each time no active edge arrives within the expected line period plus a fixed tolerance. After a programmable number of consecutive misses the reference is declared lost. The block then either tristates the loop-filter output to hold its charge, or switches the loop filter onto the free-run bias. Which of the two it does is set by a configuration bit. The reference is qualified again after two active edges arrive with no miss between them, and locking resumes at once.

Top module: `lsync_supervisor`

## Requirements
- R1: The mode is genlock when `mode_by_reg`=1 and `reg_genlock`=1, or when `mode_by_reg`=0 and `pin_genlock`=1. Otherwise it is free run.
- R2: Port B is selected (value 1) when `port_pin_off`=1 and `reg_port_b`=1. When `port_pin_off`=0, port B is selected if `port_by_reg`=1 and `reg_port_b`=1, or if `port_by_reg`=0 and `pin_port_b`=1. Otherwise port A (value 0) is selected.
- R3: With a polarity bit of 1 the rising edge of that port's sync input is the active edge, and with 0 the falling edge. After `SYNC_STAGES` input register stages, an edge is acted on at the clock edge `SYNC_STAGES` cycles after the clock edge that first samples the new level.
- R4: A miss is counted when `line_period`+`TOL` clock edges pass after an acted-on active edge (or after the previous miss) with no further active edge. The timer restarts at each miss.
- R5: A qualified reference is lost at the miss that brings the count of consecutive misses to `err_limit`+1. Any active edge clears the miss count.
- R6: From the lost state, the reference becomes qualified at the clock edge that acts on the second of two consecutive active edges with no miss between them. A single edge is not enough.
- R7: In free-run mode `ref_valid` is 0, whatever the input. `no_ref` is always the inverse of `ref_valid`.
- R8: In genlock mode with a qualified reference, `lpf_hiz`=0 and `freerun_sw`=0. In genlock mode without a qualified reference, `lpf_hiz`=1 and `freerun_sw`=0 when `holdover`=1, and `lpf_hiz`=0 and `freerun_sw`=1 when `holdover`=0. In free-run mode, `lpf_hiz`=0 and `freerun_sw`=1.
- R9: A change of the selected port drops qualification at the next clock edge. The new port must then supply two edges, as in R6.
- R10: Right after reset the reference is not qualified, so `ref_valid`=0 and `no_ref`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_a | input | 1 | Line-sync input, port A |
| hs_b | input | 1 | Line-sync input, port B |
| pol_a | input | 1 | Port A active edge: 1 rising, 0 falling |
| pol_b | input | 1 | Port B active edge: 1 rising, 0 falling |
| line_period | input | PERIOD_W | Expected line period in clock cycles |
| err_limit | input | ERR_W | Consecutive misses tolerated before loss |
| pin_genlock | input | 1 | Mode pin, 1 = genlock |
| pin_port_b | input | 1 | Port select pin, 1 = port B |
| mode_by_reg | input | 1 | 1 = mode taken from `reg_genlock` |
| reg_genlock | input | 1 | Configuration mode bit, 1 = genlock |
| port_by_reg | input | 1 | 1 = port taken from `reg_port_b` |
| reg_port_b | input | 1 | Configuration port bit, 1 = port B |
| port_pin_off | input | 1 | 1 = port always from `reg_port_b` |
| holdover | input | 1 | Action on loss: 1 holdover, 0 free run |
| ref_valid | output | 1 | Qualified reference in genlock mode |
| no_ref | output | 1 | Inverse of `ref_valid` |
| lpf_hiz | output | 1 | Tristate request for the loop-filter output |
| freerun_sw | output | 1 | Connect the free-run bias to the loop filter |

## Verification
On every cycle the assertions check these relations: the two loop-filter controls are never on together, a qualified reference in genlock mode clears both controls, and free-run mode forces `ref_valid` low. They also check that qualification only rises on an acted-on edge and only falls after a miss or a port change, and that a port change always clears it. The exact miss timing for every `err_limit` value, the two-edge recovery latency and the polarity-dependent edge timing can only be shown by the bench's timed pulse scenarios. The same holds for the pin and register priority of mode and port over all their combinations.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [1:0] {
      OP_TRACK = 2'd0,
      OP_HOLD  = 2'd1,
      OP_FREE  = 2'd2
   } lss_op_e;

   function automatic lss_op_e lss_pick_op(input logic genlock, input logic qual,
                                           input logic hold);
      if (!genlock)  return OP_FREE;
      else if (qual) return OP_TRACK;
      else if (hold) return OP_HOLD;
      else           return OP_FREE;
   endfunction

endpackage

// File: rtl/lss_edge.sv
module lss_edge #(
   parameter int N_PORTS     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_PORTS-1:0] hs,
   input  logic [N_PORTS-1:0] pol,
   output logic [N_PORTS-1:0] act_edge
);

   if (N_PORTS < 1) begin : g_bad_ports
      $error("lss_edge: N_PORTS must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("lss_edge: SYNC_STAGES must not be negative");
   end

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic lvl;
      logic samp;
      logic prev;

      // level is 1 while the port sits on the active side of its edge
      assign lvl = hs[p] ^ ~pol[p];

      if (SYNC_STAGES == 0) begin : g_direct
         assign samp = lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= lvl;
               for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign samp = chain[SYNC_STAGES-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev <= 1'b0;
         else        prev <= samp;
      end

      assign act_edge[p] = samp & ~prev;
   end

endmodule

// File: rtl/lss_select.sv
module lss_select (
   input  logic pin_genlock,
   input  logic pin_port_b,
   input  logic mode_by_reg,
   input  logic reg_genlock,
   input  logic port_by_reg,
   input  logic reg_port_b,
   input  logic port_pin_off,
   output logic genlock,
   output logic port_b
);

   always_comb begin
      genlock = mode_by_reg ? reg_genlock : pin_genlock;
      if (port_pin_off || port_by_reg) port_b = reg_port_b;
      else                             port_b = pin_port_b;
   end

endmodule

// File: rtl/lss_watch.sv
module lss_watch #(
   parameter int PERIOD_W = 16,
   parameter int TOL      = 4,
   parameter int ERR_W    = 3,
   parameter int HITS     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                edge_i,
   input  logic                clear_i,
   input  logic [PERIOD_W-1:0] line_period,
   input  logic [ERR_W-1:0]    err_limit,
   output logic                qual,
   output logic                miss_o
);

   localparam int WIN_W  = PERIOD_W + 1;
   localparam int MISS_W = ERR_W + 1;
   localparam int HIT_W  = $clog2(HITS + 1);

   if (TOL < 1 || TOL >= (1 << PERIOD_W)) begin : g_bad_tol
      $error("lss_watch: TOL must lie in 1 .. 2**PERIOD_W-1");
   end
   if (HITS < 1) begin : g_bad_hits
      $error("lss_watch: HITS must be at least 1");
   end

   logic [WIN_W-1:0]  window;
   logic [WIN_W-1:0]  timer;
   logic [MISS_W-1:0] misses;
   logic [HIT_W-1:0]  hits;

   assign window = WIN_W'(line_period) + WIN_W'(TOL);
   assign miss_o = !clear_i && !edge_i && (timer == window - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer  <= '0;
         misses <= '0;
         hits   <= '0;
         qual   <= 1'b0;
      end else if (clear_i) begin
         timer  <= '0;
         misses <= '0;
         hits   <= '0;
         qual   <= 1'b0;
      end else if (edge_i) begin
         timer  <= '0;
         misses <= '0;
         if (hits != HIT_W'(HITS)) hits <= hits + 1'b1;
         if (hits >= HIT_W'(HITS - 1)) qual <= 1'b1;
      end else if (miss_o) begin
         timer <= '0;
         hits  <= '0;
         if (misses != {MISS_W{1'b1}}) misses <= misses + 1'b1;
         if (misses >= MISS_W'(err_limit)) qual <= 1'b0;
      end else begin
         timer <= timer + 1'b1;
      end
   end

endmodule

// File: rtl/lsync_supervisor.sv
module lsync_supervisor
   import lss_pkg::*;
#(
   parameter int PERIOD_W    = 16,
   parameter int TOL         = 4,
   parameter int ERR_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int HITS        = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hs_a,
   input  logic                hs_b,
   input  logic                pol_a,
   input  logic                pol_b,
   input  logic [PERIOD_W-1:0] line_period,
   input  logic [ERR_W-1:0]    err_limit,
   input  logic                pin_genlock,
   input  logic                pin_port_b,
   input  logic                mode_by_reg,
   input  logic                reg_genlock,
   input  logic                port_by_reg,
   input  logic                reg_port_b,
   input  logic                port_pin_off,
   input  logic                holdover,
   output logic                ref_valid,
   output logic                no_ref,
   output logic                lpf_hiz,
   output logic                freerun_sw
);

   localparam int N_PORTS = 2;

   logic [N_PORTS-1:0] edges;
   logic               genlock;
   logic               port_sel;
   logic               port_prev;
   logic               sel_edge;
   logic               qual;
   logic               miss;
   lss_op_e            op;

   lss_edge #(.N_PORTS(N_PORTS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .hs       ({hs_b, hs_a}),
      .pol      ({pol_b, pol_a}),
      .act_edge (edges)
   );

   lss_select u_sel (
      .pin_genlock  (pin_genlock),
      .pin_port_b   (pin_port_b),
      .mode_by_reg  (mode_by_reg),
      .reg_genlock  (reg_genlock),
      .port_by_reg  (port_by_reg),
      .reg_port_b   (reg_port_b),
      .port_pin_off (port_pin_off),
      .genlock      (genlock),
      .port_b       (port_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_prev <= 1'b0;
      else        port_prev <= port_sel;
   end

   assign sel_edge = edges[port_sel];

   lss_watch #(.PERIOD_W(PERIOD_W), .TOL(TOL), .ERR_W(ERR_W), .HITS(HITS)) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .edge_i      (sel_edge),
      .clear_i     (port_sel != port_prev),
      .line_period (line_period),
      .err_limit   (err_limit),
      .qual        (qual),
      .miss_o      (miss)
   );

   assign op         = lss_pick_op(genlock, qual, holdover);
   assign ref_valid  = (op == OP_TRACK);
   assign no_ref     = ~ref_valid;
   assign lpf_hiz    = (op == OP_HOLD);
   assign freerun_sw = (op == OP_FREE);

endmodule

// File: rtl/lsync_supervisor_chk.sv
module lsync_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic genlock,
   input logic port_sel,
   input logic port_prev,
   input logic sel_edge,
   input logic qual,
   input logic miss,
   input logic ref_valid,
   input logic lpf_hiz,
   input logic freerun_sw
);

   AST_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lpf_hiz && freerun_sw)); // R8

   AST_TRACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |-> (!lpf_hiz && !freerun_sw)); // R8

   AST_FREERUN_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !genlock |-> (!ref_valid && freerun_sw)); // R7

   AST_QUAL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> $past(sel_edge)); // R6

   AST_LOSS_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(qual) |-> ($past(miss) || $past(port_sel != port_prev))); // R5

   AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (port_sel != port_prev) |=> !qual); // R9

endmodule

bind lsync_supervisor lsync_supervisor_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .genlock    (genlock),
   .port_sel   (port_sel),
   .port_prev  (port_prev),
   .sel_edge   (sel_edge),
   .qual       (qual),
   .miss       (miss),
   .ref_valid  (ref_valid),
   .lpf_hiz    (lpf_hiz),
   .freerun_sw (freerun_sw)
);

// File: tb/lsync_supervisor_test.sv
`timescale 1ns/1ps
module lsync_supervisor_test;

   localparam int P = 16;
   localparam int T = 4;
   localparam int S = 2;
   localparam int W = P + T;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs_a = 1'b0, hs_b = 1'b0, pol_a = 1'b1, pol_b = 1'b1;
   logic [15:0] line_period = 16'(P);
   logic [2:0]  err_limit = 3'd0;
   logic pin_genlock = 1'b0, pin_port_b = 1'b0;
   logic mode_by_reg = 1'b1, reg_genlock = 1'b1;
   logic port_by_reg = 1'b1, reg_port_b = 1'b0, port_pin_off = 1'b0;
   logic holdover = 1'b1;
   logic ref_valid, no_ref, lpf_hiz, freerun_sw;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lsync_supervisor #(.PERIOD_W(16), .TOL(T), .ERR_W(3), .SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .hs_a(hs_a), .hs_b(hs_b), .pol_a(pol_a), .pol_b(pol_b),
      .line_period(line_period), .err_limit(err_limit), .pin_genlock(pin_genlock),
      .pin_port_b(pin_port_b), .mode_by_reg(mode_by_reg), .reg_genlock(reg_genlock),
      .port_by_reg(port_by_reg), .reg_port_b(reg_port_b), .port_pin_off(port_pin_off),
      .holdover(holdover), .ref_valid(ref_valid), .no_ref(no_ref), .lpf_hiz(lpf_hiz),
      .freerun_sw(freerun_sw)
   );

   task automatic check(input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", what, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_a(input logic act);
      hs_a = act;
      @(negedge clk);
      hs_a = ~act;
   endtask

   task automatic pulse_b(input logic act);
      hs_b = act;
      @(negedge clk);
      hs_b = ~act;
   endtask

   task automatic train_a(input int n, input logic act);
      for (int k = 0; k < n; k++) begin
         pulse_a(act);
         if (k < n - 1) wait_n(P - 1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R10 reset state, genlock by register, holdover selected
      check(ref_valid, 1'b0, "R10 ref_valid after reset");
      check(no_ref, 1'b1, "R10 no_ref after reset");
      check(lpf_hiz, 1'b1, "R8 holdover while unqualified");
      check(freerun_sw, 1'b0, "R8 no free-run switch in holdover");

      // R6 two edges needed
      pulse_a(1'b1);
      wait_n(S);
      check(ref_valid, 1'b0, "R6 one edge not enough");
      wait_n(P - 1 - S);
      pulse_a(1'b1);
      wait_n(S - 1);
      check(ref_valid, 1'b0, "R6 before second edge acted on");
      wait_n(1);
      check(ref_valid, 1'b1, "R6 qualified on second edge");
      check(no_ref, 1'b0, "R7 no_ref inverse");
      check(lpf_hiz, 1'b0, "R8 tracking hiz");
      check(freerun_sw, 1'b0, "R8 tracking switch");

      // R4 R5 miss window and loss count over every limit
      for (int e = 0; e < 8; e++) begin
         err_limit = 3'(e);
         train_a(3, 1'b1);
         wait_n(S + (e + 1) * W - 1);
         check(ref_valid, 1'b1, $sformatf("R5 still valid limit %0d", e));
         wait_n(1);
         check(ref_valid, 1'b0, $sformatf("R4 R5 lost after %0d misses", e + 1));
      end

      // R8 loss actions
      check(lpf_hiz, 1'b1, "R8 holdover hiz");
      check(freerun_sw, 1'b0, "R8 holdover switch");
      holdover = 1'b0;
      #1;
      check(lpf_hiz, 1'b0, "R8 free-run on loss hiz");
      check(freerun_sw, 1'b1, "R8 free-run on loss switch");
      check(no_ref, 1'b1, "R7 no_ref on loss");
      holdover = 1'b1;

      // R1 R7 mode sources with a qualified reference
      err_limit = 3'd7;
      train_a(3, 1'b1);
      wait_n(S);
      for (int c = 0; c < 8; c++) begin
         logic g;
         {mode_by_reg, reg_genlock, pin_genlock} = 3'(c);
         g = mode_by_reg ? reg_genlock : pin_genlock;
         #1;
         check(ref_valid, g, $sformatf("R1 R7 ref_valid mode combo %0d", c));
         check(no_ref, !g, $sformatf("R7 no_ref mode combo %0d", c));
         check(freerun_sw, !g, $sformatf("R8 switch mode combo %0d", c));
         check(lpf_hiz, 1'b0, $sformatf("R8 hiz mode combo %0d", c));
      end
      mode_by_reg = 1'b1;
      reg_genlock = 1'b1;
      pin_genlock = 1'b0;
      wait_n(1);

      // R2 port sources: pulses only on port A
      for (int c = 0; c < 16; c++) begin
         logic pb;
         {port_pin_off, port_by_reg, reg_port_b, pin_port_b} = 4'(c);
         pb = (port_pin_off || port_by_reg) ? reg_port_b : pin_port_b;
         wait_n(1);
         train_a(3, 1'b1);
         wait_n(S + 1);
         check(ref_valid, !pb, $sformatf("R2 port combo %0d", c));
      end
      port_pin_off = 1'b0;
      port_by_reg = 1'b1;
      pin_port_b = 1'b0;

      // R9 port change clears qualification
      reg_port_b = 1'b1;
      wait_n(2);
      pulse_b(1'b1);
      wait_n(S);
      check(ref_valid, 1'b0, "R9 new port one edge");
      wait_n(P - 1 - S);
      pulse_b(1'b1);
      wait_n(S);
      check(ref_valid, 1'b1, "R9 new port qualified");
      reg_port_b = 1'b0;
      wait_n(1);
      check(ref_valid, 1'b0, "R9 cleared on switch back");

      // R3 falling edge on port A
      pol_a = 1'b0;
      hs_a = 1'b1;
      wait_n(2);
      pulse_a(1'b0);
      wait_n(P - 1);
      pulse_a(1'b0);
      wait_n(S - 1);
      check(ref_valid, 1'b0, "R3 falling edge not yet acted on");
      wait_n(1);
      check(ref_valid, 1'b1, "R3 falling edge acted on");

      // R3 rising-edge setting with low pulses acts one cycle later
      pol_a = 1'b1;
      wait_n(S + 2);
      reg_port_b = 1'b1;
      wait_n(1);
      reg_port_b = 1'b0;
      wait_n(1);
      pulse_a(1'b0);
      wait_n(P - 1);
      pulse_a(1'b0);
      wait_n(S);
      check(ref_valid, 1'b0, "R3 rising edge comes at pulse end");
      wait_n(1);
      check(ref_valid, 1'b1, "R3 rising edge acted on");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule